// File: doc/BRIEF.md
# Serial Flash Write-Enable Command Control

This block is the slave-side command front end of a serial flash device. It watches the four-wire serial bus (serial clock, active-low chip select, serial data in), assembles the bits clocked in during each chip-select window, and decides at the moment chip select returns high whether the window held a valid command. The block owns three pieces of state. The first is the write-enable latch that gates every program or erase operation. The second is the one-time-programmable (OTP) mode flag. The third is an internal flag that arms a single status-register write.

All serial inputs are brought into the block's own clock domain through synchronizer stages, and every decision is made on that clock. The serial data output is never driven for the commands handled here: the output-enable pin stays low and the pad remains high impedance. A status-register write leaves the block as a one-cycle strobe with its data byte. Other logic returns a completion pulse for a program or erase, and this pulse drops the write-enable latch so that every write needs a new enable command. The same logic raises a pulse to enter OTP mode.

Top module: `flash_wel_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `wel` and `otp_mode` are 0, `sr_wr_stb` is 0 and status-write arming is cleared, so a status write that follows a reset produces no strobe.
- R2: Data bits are taken most significant bit first, one on each rising edge of `spi_sck` while `spi_cs_n` is low. Both clock idle levels are accepted: low (mode 0) and high (mode 3).
- R3: A command takes effect only when `spi_cs_n` rises. A window holding any bit count other than 8 is ignored and leaves all state unchanged. The one exception is a 16-bit window that starts with opcode 0x01.
- R4: An 8-bit window with opcode 0x06 sets `wel` to 1.
- R5: An 8-bit window with opcode 0x04 clears both `wel` and `otp_mode` to 0.
- R6: An 8-bit window with opcode 0x50 arms a status write. A following 16-bit window with first byte 0x01 then drives `sr_wr_stb` high for exactly one clock, with `sr_wr_data` equal to the second byte. `sr_wr_data` holds its value at all other times.
- R7: Arming survives only until the next completed command. Any 8-bit window whose opcode is not 0x50 or 0x01 clears it, unknown opcodes included. A 16-bit 0x01 window consumes it. A 16-bit 0x01 window that arrives without arming produces no strobe.
- R8: A one-clock pulse on `wr_done` clears `wel` on the next clock. It takes priority over a simultaneous set.
- R9: A one-clock pulse on `otp_enter` sets `otp_mode` to 1.
- R10: `spi_miso_oe` and `spi_miso` are 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; serial inputs are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sck | input | 1 | Serial clock from the bus master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| wr_done | input | 1 | One-clock pulse: a program or erase has finished |
| otp_enter | input | 1 | One-clock pulse: switch into OTP mode |
| spi_miso | output | 1 | Serial data toward the master, held at 0 |
| spi_miso_oe | output | 1 | Output enable for the data pad, held at 0 |
| wel | output | 1 | Write-enable latch |
| otp_mode | output | 1 | OTP mode flag |
| sr_wr_stb | output | 1 | One-clock status-register write strobe |
| sr_wr_data | output | 8 | Data byte of the last accepted status write |

## Verification
The checker properties assume three things about the inputs. Each serial clock level and each chip-select level lasts long enough for the synchronizers to see it. Chip select never changes in the same clock as a serial clock edge. `wr_done` is only a single-cycle pulse. The stimulus meets these conditions by holding every serial clock phase for three block clocks, and by waiting several clocks before and after each chip-select transition. Data is changed only while the serial clock is low, so each bit is stable well before the rising edge that samples it.

// File: rtl/flash_wel_pkg.sv
package flash_wel_pkg;

  // Actions requested by one committed command window
  typedef struct packed {
    logic wel_set;
    logic wel_clr;
    logic arm_set;
    logic arm_clr;
    logic otp_exit;
    logic sr_stb;
  } cmd_act_t;

endpackage

// File: rtl/flash_wel_rst_sync.sv
module flash_wel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/flash_wel_in_sync.sv
module flash_wel_in_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/flash_wel_frame.sv
module flash_wel_frame #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = $clog2(2*BYTE_W+2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_i,
  input  logic                cs_n_i,
  input  logic                mosi_i,
  output logic                frame_end_o,
  output logic [CNT_W-1:0]    bit_cnt_o,
  output logic [2*BYTE_W-1:0] shreg_o
);

  localparam int SH_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SH_W + 1);

  logic              sck_q, cs_q;
  logic              sck_rise, shift_en;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SH_W-1:0]   sh_q, sh_d;

  assign sck_rise    = sck_i & ~sck_q;
  assign shift_en    = sck_rise & ~cs_n_i;
  assign frame_end_o = cs_n_i & ~cs_q;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (cs_n_i) begin
      cnt_d = '0;
    end else if (shift_en) begin
      sh_d = {sh_q[SH_W-2:0], mosi_i};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_n_i;
      cnt_q <= cnt_d;
      if (shift_en) sh_q <= sh_d;
    end
  end

  assign bit_cnt_o = cnt_q;
  assign shreg_o   = sh_q;

endmodule

// File: rtl/flash_wel_decode.sv
module flash_wel_decode
  import flash_wel_pkg::*;
#(
  parameter int              BYTE_W  = 8,
  parameter int              CNT_W   = $clog2(2*BYTE_W+2),
  parameter logic [BYTE_W-1:0] OP_SET  = 8'h06,
  parameter logic [BYTE_W-1:0] OP_CLR  = 8'h04,
  parameter logic [BYTE_W-1:0] OP_ARM  = 8'h50,
  parameter logic [BYTE_W-1:0] OP_SRW  = 8'h01
) (
  input  logic                frame_end_i,
  input  logic [CNT_W-1:0]    bit_cnt_i,
  input  logic [2*BYTE_W-1:0] shreg_i,
  input  logic                armed_i,
  output cmd_act_t            act_o
);

  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(2*BYTE_W);

  logic [BYTE_W-1:0] op_short, op_long;

  assign op_short = shreg_i[BYTE_W-1:0];
  assign op_long  = shreg_i[2*BYTE_W-1:BYTE_W];

  always_comb begin
    act_o = '0;
    if (frame_end_i) begin
      if (bit_cnt_i == LEN_SHORT) begin
        act_o.arm_clr = 1'b1;
        if (op_short == OP_SET) begin
          act_o.wel_set = 1'b1;
        end else if (op_short == OP_CLR) begin
          act_o.wel_clr  = 1'b1;
          act_o.otp_exit = 1'b1;
        end else if (op_short == OP_ARM) begin
          act_o.arm_set = 1'b1;
          act_o.arm_clr = 1'b0;
        end else if (op_short == OP_SRW) begin
          act_o.arm_clr = 1'b0;   // truncated status write: not a command
        end
      end else if (bit_cnt_i == LEN_LONG && op_long == OP_SRW) begin
        act_o.sr_stb  = armed_i;
        act_o.arm_clr = 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_wel_ctrl.sv
module flash_wel_ctrl
  import flash_wel_pkg::*;
#(
  parameter int                BYTE_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter int                RST_STAGES  = 2,
  parameter logic [BYTE_W-1:0] OP_SET      = 8'h06,
  parameter logic [BYTE_W-1:0] OP_CLR      = 8'h04,
  parameter logic [BYTE_W-1:0] OP_ARM      = 8'h50,
  parameter logic [BYTE_W-1:0] OP_SRW      = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              wr_done,
  input  logic              otp_enter,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              wel,
  output logic              otp_mode,
  output logic              sr_wr_stb,
  output logic [BYTE_W-1:0] sr_wr_data
);

  localparam int CNT_W = $clog2(2*BYTE_W+2);

  logic                rst_q_n;
  logic [2:0]          pins_s;
  logic                frame_end;
  logic [CNT_W-1:0]    bit_cnt;
  logic [2*BYTE_W-1:0] shreg;
  cmd_act_t            act;

  logic              wel_q, wel_d;
  logic              otp_q, otp_d;
  logic              arm_q, arm_d;
  logic              stb_q, stb_d;
  logic [BYTE_W-1:0] dat_q, dat_d;

  flash_wel_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_q_n)
  );

  // bit order: {sck, cs_n, mosi}; chip select idles high
  flash_wel_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d_i   ({spi_sck, spi_cs_n, spi_mosi}),
    .q_o   (pins_s)
  );

  flash_wel_frame #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .sck_i       (pins_s[2]),
    .cs_n_i      (pins_s[1]),
    .mosi_i      (pins_s[0]),
    .frame_end_o (frame_end),
    .bit_cnt_o   (bit_cnt),
    .shreg_o     (shreg)
  );

  flash_wel_decode #(
    .BYTE_W (BYTE_W), .CNT_W (CNT_W),
    .OP_SET (OP_SET), .OP_CLR (OP_CLR), .OP_ARM (OP_ARM), .OP_SRW (OP_SRW)
  ) u_dec (
    .frame_end_i (frame_end),
    .bit_cnt_i   (bit_cnt),
    .shreg_i     (shreg),
    .armed_i     (arm_q),
    .act_o       (act)
  );

  always_comb begin
    wel_d = wel_q;
    if (act.wel_clr || wr_done) wel_d = 1'b0;
    else if (act.wel_set)       wel_d = 1'b1;

    otp_d = otp_q;
    if (act.otp_exit)   otp_d = 1'b0;
    else if (otp_enter) otp_d = 1'b1;

    arm_d = arm_q;
    if (act.arm_set)      arm_d = 1'b1;
    else if (act.arm_clr) arm_d = 1'b0;

    stb_d = act.sr_stb;
    dat_d = act.sr_stb ? shreg[BYTE_W-1:0] : dat_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wel_q <= 1'b0;
      otp_q <= 1'b0;
      arm_q <= 1'b0;
      stb_q <= 1'b0;
      dat_q <= '0;
    end else begin
      wel_q <= wel_d;
      otp_q <= otp_d;
      arm_q <= arm_d;
      stb_q <= stb_d;
      if (act.sr_stb) dat_q <= dat_d;
    end
  end

  assign wel         = wel_q;
  assign otp_mode    = otp_q;
  assign sr_wr_stb   = stb_q;
  assign sr_wr_data  = dat_q;
  assign spi_miso    = 1'b0;
  assign spi_miso_oe = 1'b0;

endmodule

// File: rtl/flash_wel_ctrl_chk.sv
module flash_wel_ctrl_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_end,
  input logic              wr_done,
  input logic              wel,
  input logic              otp_mode,
  input logic              sr_wr_stb,
  input logic [BYTE_W-1:0] sr_wr_data
);

  AST_WEL_SET_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(frame_end)); // R4

  AST_WEL_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> ($past(frame_end) || $past(wr_done))); // R5

  AST_WEL_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wel); // R8

  AST_OTP_EXIT_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(otp_mode) |-> $past(frame_end)); // R5

  AST_STB_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_stb |-> $past(frame_end)); // R6

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_stb |=> !sr_wr_stb); // R6

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_wr_stb |-> $stable(sr_wr_data)); // R6

endmodule

bind flash_wel_ctrl flash_wel_ctrl_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .frame_end  (frame_end),
  .wr_done    (wr_done),
  .wel        (wel),
  .otp_mode   (otp_mode),
  .sr_wr_stb  (sr_wr_stb),
  .sr_wr_data (sr_wr_data)
);

// File: tb/flash_wel_ctrl_tb.sv
module flash_wel_ctrl_tb;

  localparam int HP = 3;  // block clocks per serial clock phase

  logic       clk = 1'b0;
  logic       rst_n, spi_sck, spi_cs_n, spi_mosi, wr_done, otp_enter;
  logic       spi_miso, spi_miso_oe, wel, otp_mode, sr_wr_stb;
  logic [7:0] sr_wr_data;

  int checks = 0, errors = 0;
  int stb_cnt = 0, so_bad = 0;
  logic [7:0] stb_last = '0;

  always #10 clk = ~clk;  // 50 MHz

  flash_wel_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .wr_done(wr_done), .otp_enter(otp_enter),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .wel(wel),
    .otp_mode(otp_mode), .sr_wr_stb(sr_wr_stb), .sr_wr_data(sr_wr_data)
  );

  always @(negedge clk) begin
    if (sr_wr_stb === 1'b1) begin
      stb_cnt  = stb_cnt + 1;
      stb_last = sr_wr_data;
    end
    if (spi_miso_oe !== 1'b0 || spi_miso !== 1'b0) so_bad = so_bad + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // n bits of 'bits', MSB first; m3 selects idle-high serial clock
  task automatic send(input logic [15:0] bits, input int n, input bit m3);
    spi_sck = m3;
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      spi_sck  = 1'b0;
      spi_mosi = bits[i];
      repeat (HP) @(negedge clk);
      spi_sck = 1'b1;
      repeat (HP) @(negedge clk);
    end
    if (!m3) spi_sck = 1'b0;
    repeat (HP) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_done();
    wr_done = 1'b1; @(negedge clk); wr_done = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic pulse_otp();
    otp_enter = 1'b1; @(negedge clk); otp_enter = 1'b0; repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    logic ew, eo;
    rst_n = 1'b0; spi_sck = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    wr_done = 1'b0; otp_enter = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 wel in reset", wel, 0);
    chk("R1 otp in reset", otp_mode, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 wel after reset", wel, 0);
    chk("R1 otp after reset", otp_mode, 0);
    chk("R1 stb after reset", sr_wr_stb, 0);

    // R4 / R2 mode 0
    send(16'h0006, 8, 1'b0);
    chk("R4 set wel mode0", wel, 1);
    // R3 wrong counts of the clear opcode
    send(16'h0004, 7, 1'b0);
    chk("R3 seven bits ignored", wel, 1);
    send(16'h0008, 9, 1'b1);
    chk("R3 nine bits ignored", wel, 1);
    // R9 / R5 / R2 mode 3
    pulse_otp();
    chk("R9 otp enter", otp_mode, 1);
    send(16'h0004, 8, 1'b1);
    chk("R5 clear wel mode3", wel, 0);
    chk("R5 leave otp", otp_mode, 0);
    send(16'h000C, 7, 1'b0);
    chk("R3 short set ignored", wel, 0);
    // R8
    send(16'h0006, 8, 1'b1);
    pulse_done();
    chk("R8 done clears wel", wel, 0);

    // R7 arming lost across another command
    s0 = stb_cnt;
    send(16'h0050, 8, 1'b0);
    send(16'h0006, 8, 1'b0);
    send(16'h01AA, 16, 1'b0);
    chk("R7 arm dropped by other cmd", stb_cnt - s0, 0);
    // R3/R6 ignored windows keep arming, then strobe
    s0 = stb_cnt;
    send(16'h0050, 8, 1'b1);
    send(16'h0015, 5, 1'b1);
    send(16'h0001, 8, 1'b1);
    chk("R3 ignored windows no strobe", stb_cnt - s0, 0);
    send(16'h013C, 16, 1'b1);
    chk("R6 one strobe", stb_cnt - s0, 1);
    chk("R6 strobe data", stb_last, 8'h3C);
    chk("R6 data held", sr_wr_data, 8'h3C);
    send(16'h01C3, 16, 1'b0);
    chk("R7 arm consumed", stb_cnt - s0, 1);

    // R1 reset mid-operation
    pulse_otp();
    send(16'h0006, 8, 1'b0);
    send(16'h0050, 8, 1'b0);
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset clears wel", wel, 0);
    chk("R1 reset clears otp", otp_mode, 0);
    s0 = stb_cnt;
    send(16'h0177, 16, 1'b0);
    chk("R1 reset clears arming", stb_cnt - s0, 0);

    // sweep of every opcode, idle level alternating
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o;
      bit m;
      o = 8'(op);
      m = o[0];
      pulse_otp();
      send(16'h0006, 8, m);
      send({8'h00, o}, 8, m);
      ew = (o == 8'h04) ? 1'b0 : 1'b1;
      eo = (o == 8'h04) ? 1'b0 : 1'b1;
      chk("R4 R5 sweep wel", wel, ew);
      chk("R5 sweep otp", otp_mode, eo);
      s0 = stb_cnt;
      send({8'h01, o ^ 8'hA5}, 16, ~m);
      if (o == 8'h50) begin
        chk("R6 sweep strobe", stb_cnt - s0, 1);
        chk("R6 sweep data", stb_last, o ^ 8'hA5);
      end else begin
        chk("R7 sweep no strobe", stb_cnt - s0, 0);
      end
    end

    chk("R10 output never enabled", so_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule